// File: doc/BRIEF.md
# Branch Shadow Annul and Interrupt Injection Controller

This block is the part of a three-stage (fetch, decode, execute) pipeline controller that decides when a conditional branch is taken. It also kills the two instructions that trail a taken branch or a jump, and slips an interrupt call into the fetch stream where doing so is safe. Each cycle it receives the decode-stage condition code, the ALU flags left by the instruction in execute, and the decoder's branch, jump and interlock indications. The block only changes state when the pipeline advance enable is high, so memory wait states freeze it together with the rest of the pipeline.

The block holds two small state machines. The annul machine has three states. In `AN_RUN` no stage is annulled. In `AN_BOTH` the decode and execute stages are both annulled. In `AN_TAIL` only the execute stage is annulled. Its transitions are: any state to `AN_BOTH` on an advance with a redirect, `AN_BOTH` to `AN_TAIL` on an advance without one, and `AN_TAIL` to `AN_RUN` on an advance without one. The interrupt machine also has three states. In `IQ_IDLE` nothing is owed. In `IQ_PEND` a request is latched and waiting for a safe slot. In `IQ_INJ` the injected call sits in decode. Its transitions, all on an advance, are: to `IQ_INJ` when the injection fires, to `IQ_PEND` when a request is present but blocked, and otherwise to `IQ_IDLE`.

When it fires, the fetched word is replaced by the constant call word 0xAE01. This word is a jump-and-link to address 0x0010 that keeps its return address in r14. While the call is in decode, the return-address hold output stops the return-address register for one pipeline cycle.

Top module: `bsh_ctrl`

## Requirements
- R1: The condition code `dc_cond` is evaluated against flags Z, N, C, V with this encoding: 0 always, 1 never, 2 Z, 3 !Z, 4 C, 5 !C, 6 N, 7 !N, 8 V, 9 !V, 10 C&!Z, 11 !C|Z, 12 N^V, 13 !(N^V), 14 !Z&!(N^V), 15 Z|(N^V).
- R2: `br_taken` is loaded on each advance with (decode holds a branch AND its condition is true AND decode is not annulled). Decode counts as annulled while `dc_annul` is high or while a redirect (taken branch or live jump) is in execute.
- R3: A redirect is a taken branch in execute, or a jump in execute that was not annulled in decode. On the advance that follows a redirect, `dc_annul` and `ex_annul` both go high. On the next advance without a redirect, only `ex_annul` stays high. On the advance after that, both go low.
- R4: An annulled jump or branch in decode causes no redirect, so it never starts a new annul sequence.
- R5: `next_word` equals 0xAE01 while `int_sel` is high and equals `fetch_word` otherwise. `int_sel` is high when a request (`irq` or a latched one) exists and nothing defers it.
- R6: Injection is deferred while `dc_interlock` is high.
- R7: Injection is deferred while decode holds a branch or jump, while a redirect is in execute, or while the previously injected call is in decode.
- R8: `ret_hold` is high from the advance on which injection occurred until the next advance.
- R9: A request seen on an advance without injection is latched and injected at the first later cycle that is not deferred, even if `irq` has dropped.
- R10: Reset clears `br_taken`, `dc_annul`, `ex_annul`, `ret_hold` and the pending request. Without an advance, no flag or state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv | input | 1 | Pipeline advance enable |
| dc_is_branch | input | 1 | Decode stage holds a conditional branch |
| dc_is_jump | input | 1 | Decode stage holds a jump or call |
| dc_interlock | input | 1 | Decode stage holds an interlocked-class instruction |
| dc_cond | input | 4 | Branch condition code of the decode instruction |
| flag_z | input | 1 | Zero flag from execute |
| flag_n | input | 1 | Negative flag from execute |
| flag_c | input | 1 | Carry-out flag from execute |
| flag_v | input | 1 | Overflow flag from execute |
| irq | input | 1 | Interrupt request |
| fetch_word | input | 16 | Word returned by the instruction fetch |
| br_taken | output | 1 | Branch in execute is taken |
| dc_annul | output | 1 | Decode-stage instruction is annulled |
| ex_annul | output | 1 | Execute-stage instruction is annulled |
| int_sel | output | 1 | Fetched word is replaced by the interrupt call |
| next_word | output | 16 | Word to load into the instruction register |
| ret_hold | output | 1 | Hold the return-address register |

## Verification
`int_sel` and `next_word` are combinational, so they are checked one nanosecond after the inputs change and before the next rising edge. `br_taken`, `ret_hold` and the annul flags change on the first advancing edge after their cause, and they are sampled one nanosecond after that edge. A redirect sets both annul flags one advance later than `br_taken` itself. The bench therefore counts the edges of each sequence explicitly, and it repeats some of them with `adv` held low to confirm that nothing moves without an advance.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_NEVER  = 4'd1,
        CC_ZERO   = 4'd2,
        CC_NZERO  = 4'd3,
        CC_CARRY  = 4'd4,
        CC_NCARRY = 4'd5,
        CC_NEG    = 4'd6,
        CC_POS    = 4'd7,
        CC_OVF    = 4'd8,
        CC_NOVF   = 4'd9,
        CC_UGT    = 4'd10,
        CC_ULE    = 4'd11,
        CC_SLT    = 4'd12,
        CC_SGE    = 4'd13,
        CC_SGT    = 4'd14,
        CC_SLE    = 4'd15
    } cond_e;

    typedef enum logic [1:0] {
        AN_RUN  = 2'd0,
        AN_BOTH = 2'd1,
        AN_TAIL = 2'd2
    } annul_e;

    typedef enum logic [1:0] {
        IQ_IDLE = 2'd0,
        IQ_PEND = 2'd1,
        IQ_INJ  = 2'd2
    } irq_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/bsh_cond_eval.sv
module bsh_cond_eval
    import bsh_pkg::*;
(
    input  logic [3:0] cond,
    input  flags_t     fl,
    output logic       hit
);
    logic lt;

    always_comb begin
        lt  = fl.n ^ fl.v;
        hit = 1'b0;
        unique case (cond_e'(cond))
            CC_ALWAYS: hit = 1'b1;
            CC_NEVER:  hit = 1'b0;
            CC_ZERO:   hit = fl.z;
            CC_NZERO:  hit = !fl.z;
            CC_CARRY:  hit = fl.c;
            CC_NCARRY: hit = !fl.c;
            CC_NEG:    hit = fl.n;
            CC_POS:    hit = !fl.n;
            CC_OVF:    hit = fl.v;
            CC_NOVF:   hit = !fl.v;
            CC_UGT:    hit = fl.c && !fl.z;
            CC_ULE:    hit = !fl.c || fl.z;
            CC_SLT:    hit = lt;
            CC_SGE:    hit = !lt;
            CC_SGT:    hit = !fl.z && !lt;
            CC_SLE:    hit = fl.z || lt;
        endcase
    end
endmodule

// File: rtl/bsh_annul_fsm.sv
module bsh_annul_fsm
    import bsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic redirect,
    output logic dc_annul,
    output logic ex_annul
);
    annul_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= AN_RUN;
        else if (adv) st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            AN_RUN:  st_nx = redirect ? AN_BOTH : AN_RUN;
            AN_BOTH: st_nx = redirect ? AN_BOTH : AN_TAIL;
            AN_TAIL: st_nx = redirect ? AN_BOTH : AN_RUN;
            default: st_nx = AN_RUN;
        endcase
    end

    always_comb begin
        dc_annul = (st == AN_BOTH);
        ex_annul = (st != AN_RUN);
    end

    // R3: a redirect on an advance annuls both stages next cycle
    a_r3_enter: assert property (@(posedge clk) disable iff (!rst_n)
        adv && redirect |=> dc_annul && ex_annul);
    // R3: the decode annul retires one advance before the execute annul
    a_r3_tail: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !redirect && dc_annul |=> !dc_annul && ex_annul);
    // R10: no advance, no change
    a_r10_hold_annul: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(dc_annul) && $stable(ex_annul));
endmodule

// File: rtl/bsh_irq_fsm.sv
module bsh_irq_fsm
    import bsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic irq,
    input  logic defer,
    output logic fire,
    output logic ret_hold
);
    irq_e st, st_nx;
    logic want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= IQ_IDLE;
        else if (adv) st <= st_nx;
    end

    always_comb begin
        want  = irq || (st == IQ_PEND);
        st_nx = st;
        unique case (st)
            IQ_IDLE: st_nx = !irq ? IQ_IDLE : (defer ? IQ_PEND : IQ_INJ);
            IQ_PEND: st_nx = defer ? IQ_PEND : IQ_INJ;
            IQ_INJ:  st_nx = irq ? IQ_PEND : IQ_IDLE;
            default: st_nx = IQ_IDLE;
        endcase
    end

    always_comb begin
        fire     = want && !defer && (st != IQ_INJ);
        ret_hold = (st == IQ_INJ);
    end

    // R8: insertion on an advance holds the return address next cycle
    a_r8_ret_hold: assert property (@(posedge clk) disable iff (!rst_n)
        adv && fire |=> ret_hold);
    // R7: never insert twice back to back
    a_r7_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hold |-> !fire);
    // R10: the hold does not move without an advance
    a_r10_hold_ret: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ret_hold));
endmodule

// File: rtl/bsh_ctrl.sv
module bsh_ctrl
    import bsh_pkg::*;
#(
    parameter int          WORD_W   = 16,
    parameter int          COND_W   = 4,
    parameter logic [15:0] INT_WORD = 16'hAE01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              dc_is_branch,
    input  logic              dc_is_jump,
    input  logic              dc_interlock,
    input  logic [COND_W-1:0] dc_cond,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic              flag_c,
    input  logic              flag_v,
    input  logic              irq,
    input  logic [WORD_W-1:0] fetch_word,
    output logic              br_taken,
    output logic              dc_annul,
    output logic              ex_annul,
    output logic              int_sel,
    output logic [WORD_W-1:0] next_word,
    output logic              ret_hold
);
    localparam logic [WORD_W-1:0] INJ_W = WORD_W'(INT_WORD);

    flags_t fl;
    logic   cond_hit;
    logic   ex_jump_q;
    logic   redirect;
    logic   dc_dead;
    logic   defer;

    assign fl = '{z: flag_z, n: flag_n, c: flag_c, v: flag_v};

    bsh_cond_eval u_cond (
        .cond (dc_cond[3:0]),
        .fl   (fl),
        .hit  (cond_hit)
    );

    assign redirect = br_taken || ex_jump_q;
    assign dc_dead  = dc_annul || redirect;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_taken  <= 1'b0;
            ex_jump_q <= 1'b0;
        end else if (adv) begin
            br_taken  <= dc_is_branch && cond_hit && !dc_dead;
            ex_jump_q <= dc_is_jump && !dc_dead;
        end
    end

    bsh_annul_fsm u_annul (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .redirect (redirect),
        .dc_annul (dc_annul),
        .ex_annul (ex_annul)
    );

    assign defer = dc_interlock || dc_is_branch || dc_is_jump || redirect;

    bsh_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .irq      (irq),
        .defer    (defer),
        .fire     (int_sel),
        .ret_hold (ret_hold)
    );

    assign next_word = int_sel ? INJ_W : fetch_word;

    // R2: nothing in an annulled decode slot becomes a taken branch
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        adv && dc_dead |=> !br_taken);
    // R6: interlocked instruction in decode blocks insertion
    a_r6_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        dc_interlock |-> !int_sel);
    // R7: no insertion while a redirect is in execute
    a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> !int_sel);
    // R10: taken flag frozen without an advance
    a_r10_hold_br: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(br_taken));
endmodule

// File: tb/tb_bsh_ctrl.sv
`timescale 1ns/1ps
module tb_bsh_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv, dc_is_branch, dc_is_jump, dc_interlock;
    logic [3:0]  dc_cond;
    logic        flag_z, flag_n, flag_c, flag_v, irq;
    logic [15:0] fetch_word;
    logic        br_taken, dc_annul, ex_annul, int_sel, ret_hold;
    logic [15:0] next_word;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    bsh_ctrl dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .dc_is_branch(dc_is_branch),
        .dc_is_jump(dc_is_jump), .dc_interlock(dc_interlock), .dc_cond(dc_cond),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
        .irq(irq), .fetch_word(fetch_word), .br_taken(br_taken),
        .dc_annul(dc_annul), .ex_annul(ex_annul), .int_sel(int_sel),
        .next_word(next_word), .ret_hold(ret_hold)
    );

    // {cond, z, n, c, v, expected taken}
    localparam logic [8:0] VEC [21] = '{
        {4'd0,  4'b0000, 1'b1}, {4'd1,  4'b1111, 1'b0},
        {4'd2,  4'b1000, 1'b1}, {4'd2,  4'b0000, 1'b0},
        {4'd3,  4'b1000, 1'b0}, {4'd3,  4'b0000, 1'b1},
        {4'd4,  4'b0010, 1'b1}, {4'd5,  4'b0010, 1'b0},
        {4'd6,  4'b0100, 1'b1}, {4'd7,  4'b0100, 1'b0},
        {4'd8,  4'b0001, 1'b1}, {4'd9,  4'b0000, 1'b1},
        {4'd10, 4'b0010, 1'b1}, {4'd10, 4'b1010, 1'b0},
        {4'd11, 4'b1010, 1'b1}, {4'd12, 4'b0100, 1'b1},
        {4'd12, 4'b0101, 1'b0}, {4'd13, 4'b0101, 1'b1},
        {4'd14, 4'b0000, 1'b1}, {4'd14, 4'b1000, 1'b0},
        {4'd15, 4'b0001, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        adv = 1'b1; dc_is_branch = 1'b0; dc_is_jump = 1'b0; dc_interlock = 1'b0;
        dc_cond = 4'd1; {flag_z, flag_n, flag_c, flag_v} = 4'b0000;
        irq = 1'b0; fetch_word = 16'h1234;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic flush();
        quiet();
        for (int k = 0; k < 3; k++) tick();
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        quiet();
        #1;
        // R10: reset state
        chk("R10 br_taken reset", {15'd0, br_taken}, 16'd0);
        chk("R10 annul reset", {14'd0, dc_annul, ex_annul}, 16'd0);
        chk("R10 ret_hold reset", {15'd0, ret_hold}, 16'd0);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R10 idle after reset", {13'd0, br_taken, dc_annul, ex_annul}, 16'd0);
        chk("R5 pass-through word", next_word, 16'h1234);

        // R1: condition table
        for (int i = 0; i < 21; i++) begin
            quiet();
            dc_is_branch = 1'b1;
            dc_cond = VEC[i][8:5];
            {flag_z, flag_n, flag_c, flag_v} = VEC[i][4:1];
            tick();
            chk($sformatf("R1 cond %0d flags %b", VEC[i][8:5], VEC[i][4:1]),
                {15'd0, br_taken}, {15'd0, VEC[i][0]});
            flush();
        end

        // R3/R2/R4/R7/R9: taken branch, shadow, pending interrupt
        quiet(); dc_is_branch = 1'b1; dc_cond = 4'd0;
        tick();
        chk("R2 taken branch", {15'd0, br_taken}, 16'd1);
        quiet(); dc_is_branch = 1'b1; dc_cond = 4'd0; irq = 1'b1;
        #1;
        chk("R7 no insert under redirect", {15'd0, int_sel}, 16'd0);
        tick();
        chk("R2 shadow branch not taken", {15'd0, br_taken}, 16'd0);
        chk("R3 both annulled", {14'd0, dc_annul, ex_annul}, 16'b11);
        quiet(); dc_is_jump = 1'b1;
        #1;
        chk("R7 jump in decode defers", {15'd0, int_sel}, 16'd0);
        tick();
        chk("R3 execute-only annul", {14'd0, dc_annul, ex_annul}, 16'b01);
        quiet();
        #1;
        chk("R9 latched request injects", {15'd0, int_sel}, 16'd1);
        chk("R5 injected word", next_word, 16'hAE01);
        tick();
        chk("R4 annulled jump no redirect", {14'd0, dc_annul, ex_annul}, 16'b00);
        chk("R8 ret_hold after insert", {15'd0, ret_hold}, 16'd1);
        irq = 1'b1;
        #1;
        chk("R7 injected call in decode defers", {15'd0, int_sel}, 16'd0);
        irq = 1'b0;
        tick();
        chk("R8 ret_hold one cycle", {15'd0, ret_hold}, 16'd0);
        flush();

        // R3: jump sequence
        quiet(); dc_is_jump = 1'b1;
        tick();
        chk("R3 jump enters execute", {14'd0, dc_annul, ex_annul}, 16'b00);
        quiet(); tick();
        chk("R3 jump annuls both", {14'd0, dc_annul, ex_annul}, 16'b11);
        tick();
        chk("R3 jump tail", {14'd0, dc_annul, ex_annul}, 16'b01);
        tick();
        chk("R3 jump clears", {14'd0, dc_annul, ex_annul}, 16'b00);

        // R10: stall
        quiet(); dc_is_branch = 1'b1; dc_cond = 4'd0;
        tick();
        quiet(); adv = 1'b0;
        tick(); tick();
        chk("R10 stall keeps taken", {15'd0, br_taken}, 16'd1);
        chk("R10 stall no annul", {14'd0, dc_annul, ex_annul}, 16'b00);
        adv = 1'b1;
        tick();
        chk("R10 advance after stall", {14'd0, dc_annul, ex_annul}, 16'b11);
        flush();

        // R5/R8/R10: direct insertion with stall
        quiet(); irq = 1'b1; fetch_word = 16'h5A5A;
        #1;
        chk("R5 insert select", {15'd0, int_sel}, 16'd1);
        chk("R5 insert word", next_word, 16'hAE01);
        tick();
        quiet(); adv = 1'b0;
        tick();
        chk("R10 ret_hold kept in stall", {15'd0, ret_hold}, 16'd1);
        adv = 1'b1;
        tick();
        chk("R8 ret_hold released", {15'd0, ret_hold}, 16'd0);

        // R6/R9: interlock defers, request latched
        quiet(); irq = 1'b1; dc_interlock = 1'b1; fetch_word = 16'h0F0F;
        #1;
        chk("R6 interlock defers", {15'd0, int_sel}, 16'd0);
        chk("R6 fetched word kept", next_word, 16'h0F0F);
        tick();
        quiet();
        #1;
        chk("R9 pending after deferral", {15'd0, int_sel}, 16'd1);
        tick();
        chk("R8 hold after deferred insert", {15'd0, ret_hold}, 16'd1);
        tick();

        // R7: branch in decode defers
        quiet(); irq = 1'b1; dc_is_branch = 1'b1; dc_cond = 4'd1;
        #1;
        chk("R7 branch in decode defers", {15'd0, int_sel}, 16'd0);
        tick();
        quiet();
        #1;
        chk("R9 pending after branch", {15'd0, int_sel}, 16'd1);
        tick(); tick();

        // R10: reset mid-sequence
        quiet(); dc_is_branch = 1'b1; dc_cond = 4'd0;
        tick();
        quiet(); tick();
        rst_n = 1'b0;
        #1;
        chk("R10 async reset clears", {13'd0, br_taken, dc_annul, ex_annul}, 16'd0);
        tick();
        rst_n = 1'b1;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule